// File: doc/BRIEF.md
# Connection Memory Bulk Fill Engine

This block initializes an entire connection memory in one operation. Software writes a five-bit pattern and a start bit to the mode register in the same access. The fill is armed only if a master enable from the control register is set. The engine then waits for the next frame strobe and walks every connection memory address in ascending order, one write per clock. Each word it writes has the pattern in its upper five bits and zero in the eleven bits below. When the last address has been written, the engine clears the start bit by itself, which is how software learns that the fill is complete.

While the engine is busy, it owns the connection memory write port, and processor writes are held off through a ready signal. Software can abort a fill in two ways: write the start bit back to zero, or drop the master enable. Either one stops the sweep at once. Entries already written keep the pattern, and the rest keep whatever they held before. The pattern is captured when the fill is triggered, so a later mode-register write that keeps the start bit at one cannot change what is written.

Top module: `cmem_block_fill`

## Requirements
- R1: Every word the engine writes carries the captured 5-bit pattern in bits 15:11 and zero in bits 10:0, and a completed fill writes each of the 1024 addresses exactly once.
- R2: A fill is triggered only by a mode write that moves the start bit from 0 to 1 while the master enable is 1. Such a write made with the enable at 0 sets the start bit but writes nothing. Raising the enable later, with no new 0-to-1 write, also writes nothing.
- R3: The pattern is taken from the same mode write that sets the start bit. Mode writes made during the fill that keep the start bit at 1 change neither the pattern nor the progress of the fill.
- R4: After the trigger, no fill write appears until a frame strobe is sampled. The first write, to address 0, appears on the connection memory port two clock edges after the edge that samples that strobe. The following writes go to consecutive ascending addresses, one per clock.
- R5: With a frame period of at least 1024 clocks, the fill completes within two frame periods of the trigger. In the cycle that the last write appears on the port, the done output pulses for one cycle, the start bit reads 0 and busy is low.
- R6: A mode write with the start bit at 0 during a fill stops it at once. Entries already written keep the pattern, the others keep their old contents, no done pulse is produced, and the start bit reads 0.
- R7: Dropping the master enable during a fill stops it in the same way as R6, except that the start bit keeps the value 1. A later write of 1 to the start bit, with no 0 written in between, does not restart the fill.
- R8: While no fill is pending or running, ready is high and a processor write appears on the connection memory port one clock later. While a fill is pending or running, ready is low and processor writes are not forwarded.
- R9: After reset, busy, done, the start bit and the port write enable are all 0, and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Master enable bit from the control register |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_start | input | 1 | Start bit value carried by the mode write |
| cfg_pattern | input | 5 | Pattern value carried by the mode write |
| frame_strobe | input | 1 | One-cycle frame boundary pulse |
| cpu_cm_we | input | 1 | Processor connection memory write request |
| cpu_cm_addr | input | 10 | Processor write address |
| cpu_cm_wdata | input | 16 | Processor write data |
| cpu_cm_ready | output | 1 | Processor write accepted when high |
| start_q | output | 1 | Current start bit, cleared by hardware on completion |
| fill_busy | output | 1 | Fill pending or running |
| fill_done | output | 1 | One-cycle pulse with the final fill write |
| cm_we | output | 1 | Connection memory write enable |
| cm_addr | output | 10 | Connection memory write address |
| cm_wdata | output | 16 | Connection memory write data |

## Verification
If the sweep counter is wrong, the port shows a skipped or repeated address, or a write count other than 1024. This is visible on the very next write cycle. If the trigger logic is wrong, a fill starts without its 0-to-1 edge or without the enable, and writes appear within one frame where none should. If the abort path is wrong, writes keep arriving after the aborting cycle, or a done pulse appears. The boundary between pattern words and preserved words in the memory image then lands at the wrong address. If the pattern capture is wrong, a mid-fill mode write shows up in bits 15:11 of the writes that follow it.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  typedef enum logic [1:0] {
    CMF_IDLE = 2'd0,
    CMF_WAIT = 2'd1,
    CMF_FILL = 2'd2
  } cmf_state_e;
endpackage

// File: rtl/cmf_trigger.sv
// Start bit register, trigger edge detection, abort decode and pattern capture.
module cmf_trigger #(
  parameter int PAT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_en,
  input  logic             cfg_wr,
  input  logic             cfg_start,
  input  logic [PAT_W-1:0] cfg_pattern,
  input  logic             busy,
  input  logic             fill_last,
  output logic             start_q,
  output logic [PAT_W-1:0] pattern_q,
  output logic             trig,
  output logic             abort
);
  logic             start_d;
  logic [PAT_W-1:0] pattern_d;
  logic             pattern_en;

  always_comb begin
    trig       = cfg_wr & cfg_start & ~start_q & blk_en & ~busy;
    abort      = busy & (~blk_en | (cfg_wr & ~cfg_start));
    pattern_en = trig;
    pattern_d  = cfg_pattern;
    start_d    = start_q;
    if (fill_last) begin
      start_d = 1'b0;
    end else if (cfg_wr) begin
      start_d = cfg_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern_q <= '0;
    end else if (pattern_en) begin
      pattern_q <= pattern_d;
    end
  end
endmodule

// File: rtl/cmf_sequencer.sv
// Frame-aligned sweep over every connection memory address.
module cmf_sequencer
  import cmf_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              abort,
  input  logic              frame_strobe,
  output logic              busy,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_last,
  output logic              done_q
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  cmf_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    addr_en   = 1'b0;
    fill_we   = 1'b0;
    fill_last = 1'b0;
    unique case (state_q)
      CMF_IDLE: begin
        if (trig) state_d = CMF_WAIT;
      end
      CMF_WAIT: begin
        if (abort) begin
          state_d = CMF_IDLE;
        end else if (frame_strobe) begin
          state_d = CMF_FILL;
          addr_d  = '0;
          addr_en = 1'b1;
        end
      end
      CMF_FILL: begin
        if (abort) begin
          state_d = CMF_IDLE;
        end else begin
          fill_we = 1'b1;
          if (addr_q == LAST_ADDR) begin
            fill_last = 1'b1;
            state_d   = CMF_IDLE;
          end else begin
            addr_d  = addr_q + 1'b1;
            addr_en = 1'b1;
          end
        end
      end
      default: state_d = CMF_IDLE;
    endcase
  end

  assign busy      = (state_q != CMF_IDLE);
  assign fill_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CMF_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fill_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/cmf_port_mux.sv
// Registered arbitration of the connection memory write port.
module cmf_port_mux #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int PAT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [PAT_W-1:0]  pattern_q,
  input  logic              cpu_cm_we,
  input  logic [ADDR_W-1:0] cpu_cm_addr,
  input  logic [DATA_W-1:0] cpu_cm_wdata,
  output logic              cpu_cm_ready,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_wdata
);
  localparam int LOW_W = DATA_W - PAT_W;

  logic              we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              port_en;

  always_comb begin
    cpu_cm_ready = ~busy;
    we_d   = 1'b0;
    addr_d = cm_addr;
    data_d = cm_wdata;
    if (fill_we) begin
      we_d   = 1'b1;
      addr_d = fill_addr;
      data_d = {pattern_q, {LOW_W{1'b0}}};
    end else if (cpu_cm_we && cpu_cm_ready) begin
      we_d   = 1'b1;
      addr_d = cpu_cm_addr;
      data_d = cpu_cm_wdata;
    end
    port_en = we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_we <= 1'b0;
    end else begin
      cm_we <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_addr  <= '0;
      cm_wdata <= '0;
    end else if (port_en) begin
      cm_addr  <= addr_d;
      cm_wdata <= data_d;
    end
  end
endmodule

// File: rtl/cmem_block_fill.sv
module cmem_block_fill #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int PAT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              cfg_wr,
  input  logic              cfg_start,
  input  logic [PAT_W-1:0]  cfg_pattern,
  input  logic              frame_strobe,
  input  logic              cpu_cm_we,
  input  logic [ADDR_W-1:0] cpu_cm_addr,
  input  logic [DATA_W-1:0] cpu_cm_wdata,
  output logic              cpu_cm_ready,
  output logic              start_q,
  output logic              fill_busy,
  output logic              fill_done,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_wdata
);
  logic              trig;
  logic              abort;
  logic              fill_we;
  logic              fill_last;
  logic [ADDR_W-1:0] fill_addr;
  logic [PAT_W-1:0]  pattern_q;

  cmf_trigger #(.PAT_W(PAT_W)) u_trigger (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_en      (blk_en),
    .cfg_wr      (cfg_wr),
    .cfg_start   (cfg_start),
    .cfg_pattern (cfg_pattern),
    .busy        (fill_busy),
    .fill_last   (fill_last),
    .start_q     (start_q),
    .pattern_q   (pattern_q),
    .trig        (trig),
    .abort       (abort)
  );

  cmf_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig         (trig),
    .abort        (abort),
    .frame_strobe (frame_strobe),
    .busy         (fill_busy),
    .fill_we      (fill_we),
    .fill_addr    (fill_addr),
    .fill_last    (fill_last),
    .done_q       (fill_done)
  );

  cmf_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_mux (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (fill_busy),
    .fill_we      (fill_we),
    .fill_addr    (fill_addr),
    .pattern_q    (pattern_q),
    .cpu_cm_we    (cpu_cm_we),
    .cpu_cm_addr  (cpu_cm_addr),
    .cpu_cm_wdata (cpu_cm_wdata),
    .cpu_cm_ready (cpu_cm_ready),
    .cm_we        (cm_we),
    .cm_addr      (cm_addr),
    .cm_wdata     (cm_wdata)
  );
endmodule

// File: rtl/cmf_checker.sv
module cmf_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int PAT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_en,
  input logic              cfg_wr,
  input logic              cfg_start,
  input logic              frame_strobe,
  input logic              cpu_cm_ready,
  input logic              start_q,
  input logic              fill_busy,
  input logic              fill_done,
  input logic              cm_we,
  input logic [ADDR_W-1:0] cm_addr,
  input logic [DATA_W-1:0] cm_wdata
);
  localparam int LOW_W = DATA_W - PAT_W;

  logic [2:0] frames_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames_busy <= '0;
    end else if (!fill_busy) begin
      frames_busy <= '0;
    end else if (frame_strobe && frames_busy != 3'd7) begin
      frames_busy <= frames_busy + 3'd1;
    end
  end

  assert_fill_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_busy) && cm_we) |-> (cm_wdata[LOW_W-1:0] == '0));

  assert_trigger_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_busy) |-> $past(blk_en && cfg_wr && cfg_start && !start_q));

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_busy) && cm_we && cm_addr != '0) |->
      ($past(cm_we) && cm_addr == ADDR_W'($past(cm_addr) + 1'b1)));

  assert_done_clears_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (!start_q && !fill_busy && cm_we));

  assert_two_frames_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> (frames_busy <= 3'd2));

  assert_abort_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_busy) && $past(cfg_wr && !cfg_start)) |-> (!fill_busy && !fill_done));

  assert_abort_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_busy) && !$past(blk_en)) |-> (!fill_busy && !fill_done));

  assert_cpu_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !cpu_cm_ready);
endmodule

bind cmem_block_fill cmf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .blk_en       (blk_en),
  .cfg_wr       (cfg_wr),
  .cfg_start    (cfg_start),
  .frame_strobe (frame_strobe),
  .cpu_cm_ready (cpu_cm_ready),
  .start_q      (start_q),
  .fill_busy    (fill_busy),
  .fill_done    (fill_done),
  .cm_we        (cm_we),
  .cm_addr      (cm_addr),
  .cm_wdata     (cm_wdata)
);

// File: tb/cmem_block_fill_tb.sv
`timescale 1ns/1ps
module cmem_block_fill_tb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int PAT_W  = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FRAME  = 1100;
  localparam logic [15:0] INIT_WORD = 16'h07FF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              blk_en = 1'b0;
  logic              cfg_wr = 1'b0;
  logic              cfg_start = 1'b0;
  logic [PAT_W-1:0]  cfg_pattern = '0;
  logic              frame_strobe = 1'b0;
  logic              cpu_cm_we = 1'b0;
  logic [ADDR_W-1:0] cpu_cm_addr = '0;
  logic [DATA_W-1:0] cpu_cm_wdata = '0;
  logic              cpu_cm_ready, start_q, fill_busy, fill_done, cm_we;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_wdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wr_count = 0;
  int done_count = 0;
  int frm_cnt = 0;
  int last_strobe_cyc = 0;
  int first_wr_cyc = 0;
  int first_wr_addr = -1;
  bit watch_first = 1'b0;
  logic [15:0] mem [DEPTH];

  always #2.5 clk = ~clk;

  cmem_block_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
    .cfg_pattern(cfg_pattern), .frame_strobe(frame_strobe), .cpu_cm_we(cpu_cm_we),
    .cpu_cm_addr(cpu_cm_addr), .cpu_cm_wdata(cpu_cm_wdata), .cpu_cm_ready(cpu_cm_ready),
    .start_q(start_q), .fill_busy(fill_busy), .fill_done(fill_done), .cm_we(cm_we),
    .cm_addr(cm_addr), .cm_wdata(cm_wdata)
  );

  // frame strobe source
  always @(negedge clk) begin
    if (!rst_n) begin
      frm_cnt = 0;
      frame_strobe <= 1'b0;
    end else if (frm_cnt == FRAME - 1) begin
      frm_cnt = 0;
      frame_strobe <= 1'b1;
    end else begin
      frm_cnt = frm_cnt + 1;
      frame_strobe <= 1'b0;
    end
  end

  // memory image and port observation
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = INIT_WORD;
    end else begin
      if (frame_strobe) last_strobe_cyc = cyc;
      if (cm_we) begin
        mem[cm_addr] = cm_wdata;
        wr_count = wr_count + 1;
        if (watch_first) begin
          watch_first   = 1'b0;
          first_wr_cyc  = cyc;
          first_wr_addr = int'(cm_addr);
        end
      end
      if (fill_done) done_count = done_count + 1;
    end
    if (cyc > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks = checks + 1;
    if (actual != expected) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic mode_write(input logic st, input logic [PAT_W-1:0] pat);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_start = st; cfg_pattern = pat;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_writes(input int target);
    for (int i = 0; i < 3000 && wr_count < target; i++) @(negedge clk);
  endtask

  // returns cycles waited until busy drops
  task automatic wait_idle(output int waited);
    waited = 0;
    while (fill_busy && waited < 4 * FRAME) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic preset_image(input logic [PAT_W-1:0] pat);
    int w;
    if (start_q) mode_write(1'b0, '0);
    mode_write(1'b1, pat);
    wait_idle(w);
    wait_cycles(2);
  endtask

  function automatic int count_mismatch(input int lo, input int hi, input logic [15:0] word);
    int n = 0;
    for (int i = lo; i < hi; i++) if (mem[i] !== word) n++;
    return n;
  endfunction

  task automatic t_reset();
    check("R9 busy after reset", int'(fill_busy), 0);
    check("R9 start after reset", int'(start_q), 0);
    check("R9 we after reset", int'(cm_we), 0);
    check("R9 done after reset", int'(fill_done), 0);
    check("R9 ready after reset", int'(cpu_cm_ready), 1);
  endtask

  task automatic t_cpu_idle();
    @(negedge clk);
    cpu_cm_we = 1'b1; cpu_cm_addr = 10'd5; cpu_cm_wdata = 16'hABCD;
    check("R8 ready while idle", int'(cpu_cm_ready), 1);
    @(negedge clk);
    cpu_cm_we = 1'b0;
    check("R8 cpu we one clock later", int'(cm_we), 1);
    check("R8 cpu addr", int'(cm_addr), 5);
    check("R8 cpu data", int'(cm_wdata), 16'hABCD);
    wait_cycles(2);
    check("R8 cpu word stored", int'(mem[5]), 16'hABCD);
  endtask

  task automatic t_no_enable();
    int base;
    blk_en = 1'b0;
    base = wr_count;
    mode_write(1'b1, 5'h11);
    wait_cycles(2 * FRAME + 20);
    check("R2 no writes with enable low", wr_count - base, 0);
    check("R2 start bit set without enable", int'(start_q), 1);
    blk_en = 1'b1;
    wait_cycles(FRAME + 20);
    check("R2 no writes after late enable", wr_count - base, 0);
    check("R2 busy stays low", int'(fill_busy), 0);
    mode_write(1'b0, '0);
    check("R2 start cleared by write", int'(start_q), 0);
  endtask

  task automatic t_full_fill();
    int base, dn, trig_cyc, waited;
    logic [15:0] word;
    word = {5'h15, 11'd0};
    blk_en = 1'b1;
    base = wr_count; dn = done_count;
    watch_first = 1'b1;
    mode_write(1'b1, 5'h15);
    trig_cyc = cyc;
    check("R8 ready low while pending", int'(cpu_cm_ready), 0);
    wait_writes(base + 200);
    // mid-fill mode write keeping start at 1 with another pattern
    mode_write(1'b1, 5'h0A);
    wait_idle(waited);
    wait_cycles(2);
    check("R4 first fill address", first_wr_addr, 0);
    check("R4 first write two edges after strobe", first_wr_cyc - last_strobe_cyc, 2);
    check("R1 write count", wr_count - base, DEPTH);
    check("R1 pattern words", count_mismatch(0, DEPTH, word), 0);
    check("R3 pattern unchanged by mid-fill write", int'(mem[DEPTH-1][15:11]), 5'h15);
    check("R5 one done pulse", done_count - dn, 1);
    check("R5 start self-cleared", int'(start_q), 0);
    check("R5 within two frames", int'(cyc - trig_cyc <= 2 * FRAME), 1);
  endtask

  task automatic t_cpu_hold();
    int waited, base;
    preset_image(5'h03);
    base = wr_count;
    mode_write(1'b1, 5'h1C);
    @(negedge clk);
    cpu_cm_we = 1'b1; cpu_cm_addr = 10'd7; cpu_cm_wdata = 16'h1234;
    wait_writes(base + 10);
    check("R8 ready low during fill", int'(cpu_cm_ready), 0);
    check("R8 held write not forwarded", int'(mem[7]), {5'h1C, 11'd0});
    wait_idle(waited);
    @(negedge clk);
    cpu_cm_we = 1'b0;
    wait_cycles(2);
    check("R8 held write lands after fill", int'(mem[7]), 16'h1234);
    check("R8 other entry keeps pattern", int'(mem[8]), {5'h1C, 11'd0});
  endtask

  task automatic t_abort_start();
    int base, n, dn;
    preset_image(5'h06);
    base = wr_count; dn = done_count;
    mode_write(1'b1, 5'h19);
    wait_writes(base + 300);
    mode_write(1'b0, 5'h19);
    n = wr_count - base;
    wait_cycles(FRAME + 10);
    check("R6 no writes after abort", wr_count - base, n);
    check("R6 partial count in range", int'(n > 0 && n < DEPTH), 1);
    check("R6 written part has new pattern", count_mismatch(0, n, {5'h19, 11'd0}), 0);
    check("R6 rest keeps old contents", count_mismatch(n, DEPTH, {5'h06, 11'd0}), 0);
    check("R6 no done pulse", done_count - dn, 0);
    check("R6 start reads zero", int'(start_q), 0);
    check("R6 busy low", int'(fill_busy), 0);
  endtask

  task automatic t_abort_enable();
    int base, n, dn;
    preset_image(5'h0C);
    base = wr_count; dn = done_count;
    mode_write(1'b1, 5'h12);
    wait_writes(base + 500);
    @(negedge clk);
    blk_en = 1'b0;
    @(negedge clk);
    n = wr_count - base;
    wait_cycles(10);
    check("R7 no writes after enable drop", wr_count - base, n);
    check("R7 written part has new pattern", count_mismatch(0, n, {5'h12, 11'd0}), 0);
    check("R7 rest keeps old contents", count_mismatch(n, DEPTH, {5'h0C, 11'd0}), 0);
    check("R7 no done pulse", done_count - dn, 0);
    check("R7 start stays one", int'(start_q), 1);
    blk_en = 1'b1;
    mode_write(1'b1, 5'h12);
    wait_cycles(FRAME + 20);
    check("R7 no restart without zero write", wr_count - base, n);
  endtask

  initial begin
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(2);
    t_reset();
    t_cpu_idle();
    t_no_enable();
    t_full_fill();
    t_cpu_hold();
    t_abort_start();
    t_abort_enable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule